// File: doc/BRIEF.md
# Lockable Charger Safety Limit Register Bank

This block is a small register bank inside a charger control interface. One register caps how far software may push the charger: its upper nibble is the ceiling for the battery regulation voltage code and its lower nibble is the ceiling for the charge current code. Two ordinary control registers hold the voltage and current codes that software asks for. Each requested code is clamped to its ceiling before it drives the setpoint outputs.

The ceiling register is open for writing only at the start of a session. The first write to any other address closes it until the next power-on reset or until the active-low limit-reset pin is pulled low. While that pin is low the ceilings are held at their default (0x00, the lowest limits) no matter what is written. Releasing the pin opens the ceiling register for writing again. A blocked write is silently dropped. The serial bus front end and the analog charger sit outside this block. It sees plain write and read strobes with an address and a data byte.

Top module: `chg_limit_regs`

## Requirements
- R1: After power-on reset (rst_n low) the ceiling register is 0x00, the lock is clear, both request registers are 0, v_set and i_set are 0 and rdata is 0x00.
- R2: The ceiling register is at address 0x06. Bits [7:4] are the voltage ceiling and bits [3:0] are the current ceiling. A write there while the lock is clear and lim_rst_n is high takes effect at the next clock edge.
- R3: A write to any address other than 0x06, defined or not, sets the lock at that clock edge while lim_rst_n is high.
- R4: While the lock is set, a write to 0x06 leaves the ceiling register unchanged and has no other effect.
- R5: At every clock edge where lim_rst_n is low, the ceiling register is forced to 0x00 and the lock is cleared, whatever is written. Once the pin is high again, a write to 0x06 is accepted.
- R6: The voltage request register is at address 0x02 and holds wdata[3:0]. v_set equals the smaller of that request and the voltage ceiling.
- R7: The current request register is at address 0x03 and holds wdata[3:0]. i_set equals the smaller of that request and the current ceiling.
- R8: A read strobe loads rdata at the next edge. Address 0x06 returns the ceiling register, locked or not. Addresses 0x02 and 0x03 return their request in bits [3:0] with zero above. Any other address returns 0x00. rdata holds its value between reads. Reads never set the lock.
- R9: The request registers are not touched by lim_rst_n. The setpoints follow any change of the ceilings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| lim_rst_n | input | 1 | Limit-reset pin, active low, level sensitive, synchronous to clk |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| v_set | output | 4 | Clamped voltage setpoint code |
| i_set | output | 4 | Clamped current setpoint code |

## Verification
The bench builds the block with its default parameters: 4-bit fields, 8-bit address, ceiling register at 0x06 and requests at 0x02 and 0x03. With these values every code is a single nibble, so the clamp cases can be chosen by hand. The vectors cover a request above its ceiling, a request below it, and a ceiling that drops under an already stored request. The 8-bit address range also allows a write to an undefined address, which shows that any non-ceiling address sets the lock. The directed tail then checks that a mid-run power-on reset clears the lock.

// File: rtl/chg_limit_pkg.sv
package chg_limit_pkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_VREQ  = 2'd2,
    SEL_IREQ  = 2'd3
  } rd_sel_e;

  // Index of each field inside the ceiling register (field k sits at bits k*W..)
  localparam int FLD_CUR  = 0;
  localparam int FLD_VOLT = 1;
  localparam int NUM_FLD  = 2;

  function automatic rd_sel_e decode_rd(input int unsigned a, input int unsigned lim_a,
                                        input int unsigned v_a, input int unsigned i_a);
    if (a == lim_a)    return SEL_LIMIT;
    else if (a == v_a) return SEL_VREQ;
    else if (a == i_a) return SEL_IREQ;
    else               return SEL_NONE;
  endfunction

endpackage

// File: rtl/limit_guard.sv
module limit_guard #(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 8,
  parameter int LIMIT_ADDR    = 6,
  parameter int LIMIT_DEFAULT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lim_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lim_q,
  output logic              lock_q,
  output logic              lim_wr_hit,
  output logic              lim_wr_blocked,
  output logic              other_wr
);
  localparam logic [DATA_W-1:0] DEF_VAL = DATA_W'(LIMIT_DEFAULT);
  localparam logic [ADDR_W-1:0] LIM_A   = ADDR_W'(LIMIT_ADDR);

  logic lim_addr_hit;

  assign lim_addr_hit   = (addr == LIM_A);
  assign lim_wr_hit     = wr_en && lim_addr_hit && !lock_q && lim_rst_n;
  assign lim_wr_blocked = wr_en && lim_addr_hit && lock_q && lim_rst_n;
  assign other_wr       = wr_en && !lim_addr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q  <= DEF_VAL;
      lock_q <= 1'b0;
    end else if (!lim_rst_n) begin
      lim_q  <= DEF_VAL;
      lock_q <= 1'b0;
    end else begin
      if (lim_wr_hit) lim_q  <= wdata;
      if (other_wr)   lock_q <= 1'b1;
    end
  end
endmodule

// File: rtl/request_bank.sv
module request_bank #(
  parameter int ADDR_W    = 8,
  parameter int FIELD_W   = 4,
  parameter int VREQ_ADDR = 2,
  parameter int IREQ_ADDR = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [FIELD_W-1:0] wfield,
  output logic [FIELD_W-1:0] vreq_q,
  output logic [FIELD_W-1:0] ireq_q
);
  localparam logic [ADDR_W-1:0] V_A = ADDR_W'(VREQ_ADDR);
  localparam logic [ADDR_W-1:0] I_A = ADDR_W'(IREQ_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vreq_q <= '0;
      ireq_q <= '0;
    end else if (wr_en) begin
      if (addr == V_A) vreq_q <= wfield;
      if (addr == I_A) ireq_q <= wfield;
    end
  end
endmodule

// File: rtl/setpoint_clamp.sv
module setpoint_clamp #(
  parameter int FIELD_W = 4
) (
  input  logic [FIELD_W-1:0] req,
  input  logic [FIELD_W-1:0] ceil,
  output logic [FIELD_W-1:0] set_o
);
  function automatic logic [FIELD_W-1:0] clamp_code(input logic [FIELD_W-1:0] r,
                                                    input logic [FIELD_W-1:0] c);
    return (r > c) ? c : r;
  endfunction

  assign set_o = clamp_code(req, ceil);
endmodule

// File: rtl/chg_limit_regs.sv
module chg_limit_regs #(
  parameter int ADDR_W        = 8,
  parameter int FIELD_W       = 4,
  parameter int LIMIT_ADDR    = 6,
  parameter int VREQ_ADDR     = 2,
  parameter int IREQ_ADDR     = 3,
  parameter int LIMIT_DEFAULT = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lim_rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [2*FIELD_W-1:0]   wdata,
  output logic [2*FIELD_W-1:0]   rdata,
  output logic [FIELD_W-1:0]     v_set,
  output logic [FIELD_W-1:0]     i_set
);
  import chg_limit_pkg::*;

  localparam int DATA_W = NUM_FLD * FIELD_W;

  logic [DATA_W-1:0]  lim_q;
  logic               lock_q;
  logic               lim_wr_hit;
  logic               lim_wr_blocked;
  logic               other_wr;
  logic [FIELD_W-1:0] vreq_q;
  logic [FIELD_W-1:0] ireq_q;
  logic [FIELD_W-1:0] req_arr [NUM_FLD];
  logic [FIELD_W-1:0] set_arr [NUM_FLD];
  logic [DATA_W-1:0]  rd_mux;
  rd_sel_e            rd_sel;

  limit_guard #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LIMIT_ADDR(LIMIT_ADDR), .LIMIT_DEFAULT(LIMIT_DEFAULT)
  ) guard_i (
    .clk(clk), .rst_n(rst_n), .lim_rst_n(lim_rst_n),
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .lim_q(lim_q), .lock_q(lock_q),
    .lim_wr_hit(lim_wr_hit), .lim_wr_blocked(lim_wr_blocked), .other_wr(other_wr)
  );

  request_bank #(
    .ADDR_W(ADDR_W), .FIELD_W(FIELD_W),
    .VREQ_ADDR(VREQ_ADDR), .IREQ_ADDR(IREQ_ADDR)
  ) req_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wfield(wdata[FIELD_W-1:0]), .vreq_q(vreq_q), .ireq_q(ireq_q)
  );

  assign req_arr[FLD_CUR]  = ireq_q;
  assign req_arr[FLD_VOLT] = vreq_q;

  for (genvar k = 0; k < NUM_FLD; k++) begin : g_clamp
    setpoint_clamp #(.FIELD_W(FIELD_W)) clamp_i (
      .req(req_arr[k]),
      .ceil(lim_q[k*FIELD_W +: FIELD_W]),
      .set_o(set_arr[k])
    );
  end

  assign v_set = set_arr[FLD_VOLT];
  assign i_set = set_arr[FLD_CUR];

  assign rd_sel = decode_rd(int'(addr), LIMIT_ADDR, VREQ_ADDR, IREQ_ADDR);

  always_comb begin
    case (rd_sel)
      SEL_LIMIT: rd_mux = lim_q;
      SEL_VREQ:  rd_mux = {{(DATA_W-FIELD_W){1'b0}}, vreq_q};
      SEL_IREQ:  rd_mux = {{(DATA_W-FIELD_W){1'b0}}, ireq_q};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/chg_limit_regs_chk.sv
module chg_limit_regs_chk #(
  parameter int ADDR_W        = 8,
  parameter int FIELD_W       = 4,
  parameter int LIMIT_ADDR    = 6,
  parameter int LIMIT_DEFAULT = 0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 lim_rst_n,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [2*FIELD_W-1:0] wdata,
  input logic [2*FIELD_W-1:0] lim_q,
  input logic                 lock_q,
  input logic                 lim_wr_blocked,
  input logic                 other_wr,
  input logic [FIELD_W-1:0]   v_set,
  input logic [FIELD_W-1:0]   i_set
);
  localparam int DATA_W = 2 * FIELD_W;
  localparam logic [ADDR_W-1:0] LIM_A   = ADDR_W'(LIMIT_ADDR);
  localparam logic [DATA_W-1:0] DEF_VAL = DATA_W'(LIMIT_DEFAULT);

  assert_accept_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == LIM_A && !lock_q && lim_rst_n) |=> (lim_q == $past(wdata)));

  assert_other_sets_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (other_wr && lim_rst_n) |=> lock_q);

  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && lim_rst_n) |=> lock_q);

  assert_blocked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lim_wr_blocked |=> $stable(lim_q));

  assert_pin_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lim_rst_n |=> (lim_q == DEF_VAL && !lock_q));

  assert_volt_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    v_set <= lim_q[DATA_W-1 -: FIELD_W]);

  assert_cur_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    i_set <= lim_q[FIELD_W-1:0]);

  assert_read_no_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !lock_q) |=> !lock_q);
endmodule

bind chg_limit_regs chg_limit_regs_chk #(
  .ADDR_W(ADDR_W), .FIELD_W(FIELD_W),
  .LIMIT_ADDR(LIMIT_ADDR), .LIMIT_DEFAULT(LIMIT_DEFAULT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .lim_rst_n(lim_rst_n),
  .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .lim_q(lim_q), .lock_q(lock_q),
  .lim_wr_blocked(lim_wr_blocked), .other_wr(other_wr),
  .v_set(v_set), .i_set(i_set)
);

// File: tb/chg_limit_regs_tb_top.sv
module chg_limit_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lim_rst_n = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] v_set;
  logic [3:0] i_set;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  chg_limit_regs dut_i (
    .clk(clk), .rst_n(rst_n), .lim_rst_n(lim_rst_n),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .v_set(v_set), .i_set(i_set)
  );

  // op: 0 idle, 1 write, 2 read
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] a;
    logic [7:0] d;
    logic       pin;
    logic [3:0] ev;
    logic [3:0] ei;
    logic [7:0] erd;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'h06, 8'hA5, 1'b1, 4'd0,  4'd0,  8'h00}, // R2 program ceilings
    '{2'd2, 8'h06, 8'h00, 1'b1, 4'd0,  4'd0,  8'hA5}, // R8 read ceiling
    '{2'd1, 8'h06, 8'h93, 1'b1, 4'd0,  4'd0,  8'h00}, // R8 read did not lock, R2 rewrite
    '{2'd1, 8'h02, 8'h0C, 1'b1, 4'd9,  4'd0,  8'h00}, // R3 lock, R6 12 clamped to 9
    '{2'd1, 8'h03, 8'h02, 1'b1, 4'd9,  4'd2,  8'h00}, // R7 2 under ceiling 3
    '{2'd1, 8'h06, 8'hFF, 1'b1, 4'd9,  4'd2,  8'h00}, // R4 blocked write
    '{2'd2, 8'h06, 8'h00, 1'b1, 4'd9,  4'd2,  8'h93}, // R4 R8 ceiling unchanged
    '{2'd1, 8'h03, 8'h0F, 1'b1, 4'd9,  4'd3,  8'h00}, // R7 15 clamped to 3
    '{2'd2, 8'h03, 8'h00, 1'b1, 4'd9,  4'd3,  8'h0F}, // R8 request readback
    '{2'd0, 8'h00, 8'h00, 1'b0, 4'd0,  4'd0,  8'h00}, // R5 pin low forces default
    '{2'd1, 8'h06, 8'hFF, 1'b0, 4'd0,  4'd0,  8'h00}, // R5 write while pin low ignored
    '{2'd2, 8'h02, 8'h00, 1'b0, 4'd0,  4'd0,  8'h0C}, // R9 request kept
    '{2'd1, 8'h06, 8'h7E, 1'b1, 4'd7,  4'd14, 8'h00}, // R5 reopened, R9 setpoints follow
    '{2'd1, 8'h10, 8'h55, 1'b1, 4'd7,  4'd14, 8'h00}, // R3 undefined address locks
    '{2'd1, 8'h06, 8'h00, 1'b1, 4'd7,  4'd14, 8'h00}, // R3 R4 blocked after that lock
    '{2'd2, 8'h10, 8'h00, 1'b1, 4'd7,  4'd14, 8'h00}  // R8 undefined reads zero
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                      input logic pin);
    @(negedge clk);
    lim_rst_n = pin;
    addr      = a;
    wdata     = d;
    wr_en     = (op == 2'd1);
    rd_en     = (op == 2'd2);
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 v_set after reset", {4'd0, v_set}, 8'h00);
    chk("R1 i_set after reset", {4'd0, i_set}, 8'h00);
    chk("R1 rdata after reset", rdata, 8'h00);
    step(2'd2, 8'h06, 8'h00, 1'b1);
    chk("R1 ceiling reads default", rdata, 8'h00);

    for (int k = 0; k < NV; k++) begin
      step(VECS[k].op, VECS[k].a, VECS[k].d, VECS[k].pin);
      chk($sformatf("vector %0d v_set", k), {4'd0, v_set}, {4'd0, VECS[k].ev});
      chk($sformatf("vector %0d i_set", k), {4'd0, i_set}, {4'd0, VECS[k].ei});
      if (VECS[k].op == 2'd2)
        chk($sformatf("vector %0d rdata", k), rdata, VECS[k].erd);
    end

    // R1: power-on reset mid-run clears the lock and the requests
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 v_set after re-reset", {4'd0, v_set}, 8'h00);
    step(2'd1, 8'h06, 8'h33, 1'b1);
    step(2'd2, 8'h06, 8'h00, 1'b1);
    chk("R1 ceiling writable after re-reset", rdata, 8'h33);
    step(2'd2, 8'h02, 8'h00, 1'b1);
    chk("R1 voltage request cleared", rdata, 8'h00);

    // R6 with ceiling 3: request 2 passes through unclamped
    step(2'd1, 8'h02, 8'hF2, 1'b1);
    chk("R6 request below ceiling", {4'd0, v_set}, 8'h02);
    // R8 rdata holds between reads
    step(2'd0, 8'h06, 8'h00, 1'b1);
    chk("R8 rdata holds", rdata, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule